// File: doc/BRIEF.md
# Single-Precision Multiplier with Subnormal Handling

This block multiplies two 32-bit binary floating-point operands. The sign of the result is the exclusive-OR of the operand signs. A subnormal operand is first normalised: its fraction is moved left until the hidden-bit position is set, and its exponent drops by the same amount. The two 24-bit significands are multiplied into a 64-bit product. That product is folded to 32 bits with a sticky bit and, if needed, moved left one place. The result then passes through a rounder that supports two modes and packs the output word. The rounder raises overflow, underflow and inexact cause flags.

A zero operand gives a signed zero before any check for infinity, so zero times infinity yields zero. An infinite operand is not packed directly: its exponent of all ones is sent through the rounder's overflow path. Operands with an all-ones exponent and a non-zero fraction get no special treatment and are multiplied as ordinary numbers.

Work starts on a one-cycle strobe. The operation runs through three internal stages and ends with a one-cycle done pulse. While an operation is in flight, further strobes are dropped.

Top module: `fpm_mul32`

## Requirements
- R1: The result sign is in_a[31] XOR in_b[31]. If either operand has exponent field 0 and fraction 0, the result is that signed zero with no flags raised, even when the other operand is infinite.
- R2: If neither operand is zero and one has exponent 0xFF with fraction 0, out_flags is 3'b101 (bit 2 overflow, bit 1 underflow, bit 0 inexact). out_prod is the signed infinity (magnitude 0x7F800000) when in_rz=0, and the signed largest finite value (magnitude 0x7F7FFFFF) when in_rz=1.
- R3: Finite products are rounded to nearest with ties to even when in_rz=0 and truncated toward zero when in_rz=1. Inexact (bit 0) is raised whenever any discarded bit is non-zero.
- R4: Subnormal operands are normalised before the multiply. A product below the normal range is shifted right with sticky to give a subnormal or zero result. Underflow (bit 1) is raised when the result is tiny and inexact, and underflow always comes with inexact.
- R5: A finite product above the largest finite value gives the same outputs and flags as R2.
- R6: An operand with exponent 0xFF and a non-zero fraction is multiplied as the number 1.f × 2^128, with no special-value detection.
- R7: A strobe accepted at clock edge k makes out_done high for exactly the one cycle after edge k+3, with out_prod and out_flags valid then. Both outputs hold their values until the next done pulse.
- R8: in_valid is ignored at the three edges that follow an accepted strobe. No second result is produced and the first result is not disturbed.
- R9: After synchronous reset, out_done, out_prod and out_flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start strobe, taken only when idle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_rz | input | 1 | Rounding mode: 0 nearest-even, 1 toward zero |
| out_done | output | 1 | One-cycle pulse when the result is ready |
| out_prod | output | 32 | Packed product |
| out_flags | output | 3 | {overflow, underflow, inexact} |

## Verification
Each product is due exactly three edges after the edge that accepted its strobe. The bench keeps its own cycle counter and records that due cycle when it sees the strobe accepted. On every falling edge it compares out_done with "counter equals due cycle". On the cycle where a result is expected, it also compares the product and flags with a behavioural model. Directed cases read the outputs on that same falling edge. The busy test holds the strobe high with other operands across the in-flight edges, then checks on the following cycle that no second pulse appeared and the first product is unchanged.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int WORD_W  = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int MAN_W   = FRAC_W + 1;
    localparam int EXPI_W  = 10;
    localparam int SIG_W   = 32;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int RND_W   = 7;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int EXP_OVF = EXP_MAX - 2;
    localparam int LZ_W    = $clog2(MAN_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UNPK,
        ST_MUL,
        ST_RND
    } fpm_state_t;

    typedef struct packed {
        logic                     is_zero;
        logic                     is_inf;
        logic signed [EXPI_W-1:0] exp;
        logic [MAN_W-1:0]         man;
    } fpm_opnd_t;

    typedef struct packed {
        logic                     sign;
        logic                     is_zero;
        logic signed [EXPI_W-1:0] exp;
        logic [SIG_W-1:0]         sig;
    } fpm_mid_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } fpm_flags_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FRAC_W-1:0] f);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = LZ_W'(FRAC_W);
        seen = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!seen && f[i]) begin
                n    = LZ_W'(FRAC_W - 1 - i);
                seen = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-2:0] mag,
    output fpm_opnd_t         opnd
);
    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] ff;
    logic [LZ_W-1:0]   sh;

    always_comb begin
        ef = mag[WORD_W-2 -: EXP_W];
        ff = mag[FRAC_W-1:0];
        sh = lead_zeros(ff) + LZ_W'(1);
        opnd.is_zero = (ef == '0) && (ff == '0);
        opnd.is_inf  = (ef == EXP_W'(EXP_MAX)) && (ff == '0);
        if (ef == '0) begin
            opnd.man = {1'b0, ff} << sh;
            opnd.exp = EXPI_W'(1) - $signed({{(EXPI_W-LZ_W){1'b0}}, sh});
        end else begin
            opnd.man = {1'b1, ff};
            opnd.exp = $signed({{(EXPI_W-EXP_W){1'b0}}, ef});
        end
    end
endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul
    import fpm_pkg::*;
(
    input  logic      sign,
    input  fpm_opnd_t opa,
    input  fpm_opnd_t opb,
    output fpm_mid_t  mid
);
    logic [SIG_W-1:0]         ma, mb, folded;
    logic [PROD_W-1:0]        prod;
    logic signed [EXPI_W-1:0] esum;

    always_comb begin
        ma     = {1'b0, opa.man, 7'b0};
        mb     = {opb.man, 8'b0};
        prod   = PROD_W'(ma) * PROD_W'(mb);
        folded = prod[PROD_W-1:SIG_W] | {{(SIG_W-1){1'b0}}, |prod[SIG_W-1:0]};
        esum   = $signed(opa.exp) + $signed(opb.exp) - EXPI_W'(BIAS);

        mid.sign    = sign;
        mid.is_zero = opa.is_zero || opb.is_zero;
        if (opa.is_inf || opb.is_inf) begin
            mid.exp = EXPI_W'(EXP_MAX);
            mid.sig = '0;
        end else if (!folded[SIG_W-2]) begin
            mid.exp = esum - EXPI_W'(1);
            mid.sig = folded << 1;
        end else begin
            mid.exp = esum;
            mid.sig = folded;
        end
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  fpm_mid_t          mid,
    input  logic              rz,
    output logic [WORD_W-1:0] word,
    output fpm_flags_t        flags
);
    logic [SIG_W:0]           inc, pre_sum, sum;
    logic signed [EXPI_W-1:0] e_in, e_out;
    logic [EXPI_W-1:0]        amt;
    logic [SIG_W-1:0]         mask, jammed, sig_r, kept;
    logic [RND_W-1:0]         rbits;
    logic                     neg, tiny, ovf_hit;

    always_comb begin
        inc     = rz ? '0 : (SIG_W+1)'(1 << (RND_W - 1));
        e_in    = $signed(mid.exp);
        pre_sum = {1'b0, mid.sig} + inc;
        ovf_hit = (e_in > EXPI_W'(EXP_OVF)) ||
                  ((e_in == EXPI_W'(EXP_OVF)) && pre_sum[SIG_W-1]);
        neg     = e_in[EXPI_W-1];
        tiny    = (e_in < -EXPI_W'(1)) || !pre_sum[SIG_W-1];
        amt     = EXPI_W'(-e_in);
        mask    = (SIG_W'(1) << amt[4:0]) - SIG_W'(1);
        if (amt >= EXPI_W'(SIG_W))
            jammed = {{(SIG_W-1){1'b0}}, |mid.sig};
        else
            jammed = (mid.sig >> amt[4:0]) | {{(SIG_W-1){1'b0}}, |(mid.sig & mask)};
        sig_r = neg ? jammed : mid.sig;
        e_out = neg ? '0 : e_in;
        rbits = sig_r[RND_W-1:0];
        sum   = {1'b0, sig_r} + inc;
        kept  = sum[SIG_W:RND_W];
        if (!rz && rbits == RND_W'(1 << (RND_W - 1)))
            kept[0] = 1'b0;
        if (kept == '0)
            e_out = '0;

        if (mid.is_zero) begin
            word  = {mid.sign, {(WORD_W-1){1'b0}}};
            flags = '0;
        end else if (ovf_hit) begin
            word  = {mid.sign, rz ? 31'h7F7F_FFFF : 31'h7F80_0000};
            flags = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
        end else begin
            word  = {mid.sign, {(WORD_W-1){1'b0}}}
                  + ({{(WORD_W-EXP_W){1'b0}}, e_out[EXP_W-1:0]} << FRAC_W)
                  + kept;
            flags = '{ovf: 1'b0,
                      unf: neg && tiny && (rbits != '0),
                      inx: rbits != '0};
        end
    end
endmodule

// File: rtl/fpm_mul32.sv
module fpm_mul32
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic              in_rz,
    output logic              out_done,
    output logic [WORD_W-1:0] out_prod,
    output logic [2:0]        out_flags
);
    localparam int N_OPS = 2;

    fpm_state_t        state;
    logic              accept;
    logic [WORD_W-1:0] word_q [N_OPS];
    logic              rz_q, sign_q;
    fpm_opnd_t         opnd_w [N_OPS];
    fpm_opnd_t         opnd_q [N_OPS];
    fpm_mid_t          mid_w, mid_q;
    logic [WORD_W-1:0] rnd_word;
    fpm_flags_t        rnd_flags;

    assign accept = in_valid && (state == ST_IDLE) && !rst;

    for (genvar g = 0; g < N_OPS; g++) begin : g_unpk
        fpm_unpack u_unpk (
            .mag  (word_q[g][WORD_W-2:0]),
            .opnd (opnd_w[g])
        );
    end

    fpm_sigmul u_mul (
        .sign (sign_q),
        .opa  (opnd_q[0]),
        .opb  (opnd_q[1]),
        .mid  (mid_w)
    );

    fpm_round u_rnd (
        .mid   (mid_q),
        .rz    (rz_q),
        .word  (rnd_word),
        .flags (rnd_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            out_done  <= 1'b0;
            out_prod  <= '0;
            out_flags <= '0;
        end else begin
            out_done <= (state == ST_RND);
            case (state)
                ST_IDLE: if (accept) state <= ST_UNPK;
                ST_UNPK: state <= ST_MUL;
                ST_MUL:  state <= ST_RND;
                default: begin
                    state     <= ST_IDLE;
                    out_prod  <= rnd_word;
                    out_flags <= rnd_flags;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            word_q[0] <= in_a;
            word_q[1] <= in_b;
            rz_q      <= in_rz;
        end
        if (state == ST_UNPK) begin
            opnd_q <= opnd_w;
            sign_q <= word_q[0][WORD_W-1] ^ word_q[1][WORD_W-1];
        end
        if (state == ST_MUL)
            mid_q <= mid_w;
    end
endmodule

// File: rtl/fpm_mul32_chk.sv
module fpm_mul32_chk (
    input logic        clk,
    input logic        rst,
    input logic        accept,
    input logic        out_done,
    input logic [31:0] out_prod,
    input logic [2:0]  out_flags
);
    AST_DONE_AFTER_THREE: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(accept, 4)) else $error("done without matching accept"); // R7
    AST_ACCEPT_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
        $past(accept, 4) |-> out_done) else $error("accept without done"); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done) else $error("done longer than one cycle"); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_prod) && $stable(out_flags))) else $error("result moved"); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        ($past(accept, 1) || $past(accept, 2) || $past(accept, 3)) |-> !accept)
        else $error("strobe taken while busy"); // R8
    AST_OVF_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_flags[2]) |->
        (out_flags[0] && !out_flags[1] &&
         (out_prod[30:0] == 31'h7F80_0000 || out_prod[30:0] == 31'h7F7F_FFFF)))
        else $error("overflow result malformed"); // R5
    AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (rst)
        (out_done && out_flags[1]) |-> (out_flags[0] && out_prod[30:24] == 7'd0))
        else $error("underflow without inexact or tiny result"); // R4
endmodule

bind fpm_mul32 fpm_mul32_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .out_done  (out_done),
    .out_prod  (out_prod),
    .out_flags (out_flags)
);

// File: tb/fpm_mul32_bench.sv
module fpm_mul32_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        in_rz = 1'b0;
    logic        out_done;
    logic [31:0] out_prod;
    logic [2:0]  out_flags;

    int          cyc = 0;
    int          due = -10;
    bit          pending = 1'b0;
    logic [34:0] exp_res = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    string       cur_req = "R3";
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    fpm_mul32 u_fpm_mul32 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_rz(in_rz), .out_done(out_done), .out_prod(out_prod), .out_flags(out_flags)
    );

    function automatic logic [34:0] ref_round(input logic s, input int e_in,
                                              input longint unsigned z_in, input logic rz);
        longint unsigned z, inc, rb;
        int  e;
        logic tiny, uf;
        logic [31:0] w;
        z = z_in; e = e_in; uf = 1'b0;
        inc = rz ? 0 : 64;
        rb  = z & 127;
        if (e > 253 || (e == 253 && z + inc >= 64'h8000_0000))
            return {3'b101, s, rz ? 31'h7F7F_FFFF : 31'h7F80_0000};
        if (e < 0) begin
            tiny = (e < -1) || (z + inc < 64'h8000_0000);
            if (-e >= 32) z = (z != 0) ? 1 : 0;
            else z = (z >> (-e)) | (((z & ((64'd1 << (-e)) - 1)) != 0) ? 1 : 0);
            e  = 0;
            rb = z & 127;
            uf = tiny && (rb != 0);
        end
        z = (z + inc) >> 7;
        if (!rz && rb == 64) z = z & ~64'd1;
        if (z == 0) e = 0;
        w = 32'((longint'(s) << 31) + (longint'(e) << 23) + z);
        return {1'b0, uf, rb != 0, w};
    endfunction

    function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic rz);
        logic s;
        int ea, eb, e;
        longint unsigned fa, fb, p, z;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        fa = longint'(a[22:0]); fb = longint'(b[22:0]);
        if ((ea == 0 && fa == 0) || (eb == 0 && fb == 0)) return {3'b000, s, 31'd0};
        if ((ea == 255 && fa == 0) || (eb == 255 && fb == 0)) return ref_round(s, 255, 0, rz);
        if (ea == 0) begin
            ea = 1;
            while (fa < 64'h80_0000) begin fa = fa << 1; ea = ea - 1; end
        end else fa = fa | 64'h80_0000;
        if (eb == 0) begin
            eb = 1;
            while (fb < 64'h80_0000) begin fb = fb << 1; eb = eb - 1; end
        end else fb = fb | 64'h80_0000;
        e = ea + eb - 127;
        p = (fa << 7) * (fb << 8);
        z = (p >> 32) | (((p & 64'hFFFF_FFFF) != 0) ? 1 : 0);
        if (z[30] == 1'b0) begin z = z << 1; e = e - 1; end
        return ref_round(s, e, z, rz);
    endfunction

    task automatic bad(input string req, input logic [34:0] act, input logic [34:0] expv);
        n_fail++;
        $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, expv, cyc);
    endtask

    // acceptance tracker: mirrors the idle/busy rule of R7/R8
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            pending = 1'b0;
            due = -10;
        end else if (!pending && in_valid) begin
            pending = 1'b1;
            due     = cyc + 3;
            exp_res = ref_mul(in_a, in_b, in_rz);
        end else if (pending && cyc == due) begin
            pending = 1'b0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (out_done || cyc == due) begin
                n_chk++;
                if (out_done !== (cyc == due))
                    bad("R7", {34'd0, out_done}, {34'd0, cyc == due});
                else begin
                    n_chk++;
                    if ({out_flags, out_prod} !== exp_res) bad(cur_req, {out_flags, out_prod}, exp_res);
                end
            end
        end
    end

    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic rz,
                         input logic [31:0] hp, input logic [2:0] hf, input string req);
        cur_req = req;
        @(negedge clk);
        in_a = a; in_b = b; in_rz = rz; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if ({out_done, out_flags, out_prod} !== {1'b1, hf, hp})
            bad(req, {out_flags, out_prod}, {hf, hp});
    endtask

    task automatic rand_op();
        logic [31:0] a, b;
        for (int k = 0; k < 2; k++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            if (k == 0) a = rng; else b = rng;
        end
        case (rng[9:8])
            2'd1: a[30:23] = 8'd0;
            2'd2: begin a[30:23] = 8'd100 + 8'(rng[5:0]); b[30:23] = 8'd100 + 8'(rng[15:10]); end
            2'd3: b[30:23] = rng[16] ? 8'hFE : 8'h10;
            default: ;
        endcase
        cur_req = "R3";
        @(negedge clk);
        in_a = a; in_b = b; in_rz = rng[20]; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if ({out_done, out_flags, out_prod} !== 36'd0)
            bad("R9", {out_flags, out_prod}, 35'd0);

        do_op(32'h8000_0000, 32'h7F80_0000, 1'b0, 32'h8000_0000, 3'b000, "R1");
        do_op(32'h0000_0000, 32'hFF80_0000, 1'b1, 32'h8000_0000, 3'b000, "R1");
        do_op(32'hC000_0000, 32'h4040_0000, 1'b0, 32'hC0C0_0000, 3'b000, "R1");
        do_op(32'h7F80_0000, 32'h4000_0000, 1'b0, 32'h7F80_0000, 3'b101, "R2");
        do_op(32'h7F80_0000, 32'h4000_0000, 1'b1, 32'h7F7F_FFFF, 3'b101, "R2");
        do_op(32'hFF80_0000, 32'h0000_0001, 1'b0, 32'hFF80_0000, 3'b101, "R2");
        do_op(32'h3F80_0000, 32'h3F80_0000, 1'b0, 32'h3F80_0000, 3'b000, "R3");
        do_op(32'h3F80_0001, 32'h3FC0_0000, 1'b0, 32'h3FC0_0002, 3'b001, "R3");
        do_op(32'h3F80_0001, 32'h3FC0_0000, 1'b1, 32'h3FC0_0001, 3'b001, "R3");
        do_op(32'h3F80_0003, 32'h3FC0_0000, 1'b0, 32'h3FC0_0004, 3'b001, "R3");
        do_op(32'h0000_0001, 32'h3F80_0000, 1'b0, 32'h0000_0001, 3'b000, "R4");
        do_op(32'h0040_0000, 32'h4000_0000, 1'b0, 32'h0080_0000, 3'b000, "R4");
        do_op(32'h0080_0000, 32'h0080_0000, 1'b0, 32'h0000_0000, 3'b011, "R4");
        do_op(32'h7F00_0000, 32'h7F00_0000, 1'b0, 32'h7F80_0000, 3'b101, "R5");
        do_op(32'h7F00_0000, 32'hFF00_0000, 1'b1, 32'hFF7F_FFFF, 3'b101, "R5");
        do_op(32'h7FC0_0000, 32'h3F80_0000, 1'b0, 32'h7F80_0000, 3'b101, "R6");
        do_op(32'h7FC0_0000, 32'h0080_0000, 1'b0, 32'h40C0_0000, 3'b000, "R6");

        // R8: strobe held with other operands while busy
        cur_req = "R8";
        @(negedge clk);
        in_a = 32'h4000_0000; in_b = 32'h4040_0000; in_rz = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_a = 32'h7F80_0000; in_b = 32'h3F80_0000; in_rz = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        n_chk++;
        if ({out_done, out_flags, out_prod} !== {1'b1, 3'b000, 32'h40C0_0000})
            bad("R8", {out_flags, out_prod}, {3'b000, 32'h40C0_0000});
        @(negedge clk);
        n_chk++;
        if ({out_done, out_flags, out_prod} !== {1'b0, 3'b000, 32'h40C0_0000})
            bad("R8", {out_flags, out_prod}, {3'b000, 32'h40C0_0000});

        for (int i = 0; i < 400; i++) rand_op();

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule